// File: doc/BRIEF.md
# Load/Store Address Guard with Character Output

This block sits between the address path of a small 32-bit load/store core and its word memory. For every data access it adds a signed 16-bit displacement to a base register value, wrapping at 2^32. It classifies the resulting effective address and decides whether the external memory may be written. A store to one fixed output location never reaches memory. Instead, the low byte of the store data leaves the block on a registered character port as a one-cycle strobe.

The same address classifier screens every candidate program-counter value the core presents. A target is accepted if it is a legal word address. One fixed halt value, which lies outside the memory range, is also accepted. Faults on loads, stores and program-counter targets each latch their own flag. A flag stays set until reset, so the surrounding system can inspect it after the failing access.

Legal word addresses are word-aligned (two low bits zero) and lie below 0x0100_0000. The output location is 0xFFFF_000C, and the halt value is 0xFEE1_DEAD. The reset is asynchronous and active-low. Its release is synchronised inside the block, so internal state leaves reset on the second rising clock edge after the reset input rises.

Top module: `lsu_addr_guard`

## Requirements
- R1: `ea_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32. It follows the inputs in the same cycle, with no register.
- R2: During a store, `mem_we_o` is high in the same cycle exactly when `ea_o[1:0]` is 0 and `ea_o` is below 0x0100_0000 when read as unsigned.
- R3: A store whose effective address is 0xFFFF_000C never raises `mem_we_o` and never changes memory. On the next cycle, `char_vld_o` is high and `char_o` equals `store_data_i[7:0]` of that store.
- R4: `char_vld_o` is high only in the cycle after a store to the output location. `char_o` keeps its last value until the next such store.
- R5: A load to an illegal address raises `ld_fault_o` one cycle later. This includes a load from 0xFFFF_000C. The flag then stays high until reset. A load to a legal address does not raise it.
- R6: A store to an illegal address other than 0xFFFF_000C raises `st_fault_o` one cycle later. The flag then stays high until reset. `mem_we_o` stays low for that store.
- R7: When `pc_upd_i` is high, `pc_fault_o` rises one cycle later unless `pc_next_i` is either a legal address or exactly 0xFEE1_DEAD. Once set, it stays high until reset.
- R8: While `rst_n` is low, all three fault flags, `char_vld_o` and `char_o` are 0. Asserting `rst_n` clears any flag that was set.
- R9: Addresses presented without their strobe have no effect. This covers `load_i`, `store_i` and `pc_upd_i` all being low: no fault flag rises, `mem_we_o` stays low, and no character is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| load_i | input | 1 | Load access strobe |
| store_i | input | 1 | Store access strobe |
| store_data_i | input | 32 | Store data word |
| pc_next_i | input | 32 | Candidate program-counter value |
| pc_upd_i | input | 1 | Candidate PC is being taken this cycle |
| ea_o | output | 32 | Effective address |
| mem_we_o | output | 1 | Write enable to the word memory |
| ld_fault_o | output | 1 | Sticky load address fault |
| st_fault_o | output | 1 | Sticky store address fault |
| pc_fault_o | output | 1 | Sticky PC target fault |
| char_vld_o | output | 1 | Output character strobe |
| char_o | output | 8 | Output character |

## Verification
The effective address and the memory write enable are combinational. The bench checks them in the same cycle the inputs are driven, two nanoseconds after the falling edge where the stimulus changes. The fault flags and the character port are registered. They are checked one full cycle later, at the next falling edge, and checked again on later idle cycles to confirm stickiness and the single-cycle strobe. After reset release, the bench waits out the two synchroniser stages before it drives any access.

// File: rtl/lsu_guard_pkg.sv
package lsu_guard_pkg;

  // Classification of one address against the guard rules.
  typedef struct packed {
    logic aligned;   // low bits select a whole word
    logic in_range;  // below the memory limit
    logic is_out;    // equals the character output location
    logic is_halt;   // equals the halt program-counter value
  } addr_class_t;

  function automatic logic cls_legal(addr_class_t c);
    return c.aligned & c.in_range;
  endfunction

endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] ea_o
);

  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    ea_o    = base_i + off_ext;
  end

endmodule

// File: rtl/lsu_addr_class.sv
module lsu_addr_class
  import lsu_guard_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] MEM_LIMIT  = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] OUT_ADDR   = 32'hFFFF_000C,
  parameter logic [ADDR_W-1:0] HALT_PC    = 32'hFEE1_DEAD
) (
  input  logic [ADDR_W-1:0] addr_i,
  output addr_class_t       cls_o
);

  localparam int unsigned ALIGN_BITS = $clog2(WORD_BYTES);

  generate
    if (ALIGN_BITS == 0) begin : g_byte
      always_comb cls_o.aligned = 1'b1;
    end else begin : g_word
      always_comb cls_o.aligned = ~|addr_i[ALIGN_BITS-1:0];
    end
  endgenerate

  always_comb begin
    cls_o.in_range = (addr_i < MEM_LIMIT);
    cls_o.is_out   = (addr_i == OUT_ADDR);
    cls_o.is_halt  = (addr_i == HALT_PC);
  end

endmodule

// File: rtl/lsu_guard_regs.sv
module lsu_guard_regs #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_bad_i,
  input  logic              st_bad_i,
  input  logic              pc_bad_i,
  input  logic              emit_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic              ld_fault_o,
  output logic              st_fault_o,
  output logic              pc_fault_o,
  output logic              char_vld_o,
  output logic [CHAR_W-1:0] char_o
);

  logic              ld_q, st_q, pc_q, vld_q;
  logic              ld_d, st_d, pc_d, vld_d;
  logic [CHAR_W-1:0] char_q, char_d;
  logic              char_en;

  // Next-state logic
  always_comb begin
    ld_d    = ld_q | ld_bad_i;
    st_d    = st_q | st_bad_i;
    pc_d    = pc_q | pc_bad_i;
    vld_d   = emit_i;
    char_en = emit_i;
    char_d  = char_i;
  end

  // Sticky flags and strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= 1'b0;
      st_q  <= 1'b0;
      pc_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      ld_q  <= ld_d;
      st_q  <= st_d;
      pc_q  <= pc_d;
      vld_q <= vld_d;
    end
  end

  // Character holding register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
    end else if (char_en) begin
      char_q <= char_d;
    end
  end

  assign ld_fault_o = ld_q;
  assign st_fault_o = st_q;
  assign pc_fault_o = pc_q;
  assign char_vld_o = vld_q;
  assign char_o     = char_q;

endmodule

// File: rtl/lsu_addr_guard.sv
module lsu_addr_guard
  import lsu_guard_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       OFF_W       = 16,
  parameter int unsigned       CHAR_W      = 8,
  parameter int unsigned       WORD_BYTES  = 4,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] MEM_LIMIT   = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] OUT_ADDR    = 32'hFFFF_000C,
  parameter logic [ADDR_W-1:0] HALT_PC     = 32'hFEE1_DEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              load_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] store_data_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic              pc_upd_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              mem_we_o,
  output logic              ld_fault_o,
  output logic              st_fault_o,
  output logic              pc_fault_o,
  output logic              char_vld_o,
  output logic [CHAR_W-1:0] char_o
);

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // Address datapath
  logic [ADDR_W-1:0] ea;
  addr_class_t       ea_cls, pc_cls;

  lsu_ea_adder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
    .base_i   (base_i),
    .offset_i (offset_i),
    .ea_o     (ea)
  );

  lsu_addr_class #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .MEM_LIMIT(MEM_LIMIT),
    .OUT_ADDR(OUT_ADDR), .HALT_PC(HALT_PC)
  ) u_ea_cls (
    .addr_i (ea),
    .cls_o  (ea_cls)
  );

  lsu_addr_class #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .MEM_LIMIT(MEM_LIMIT),
    .OUT_ADDR(OUT_ADDR), .HALT_PC(HALT_PC)
  ) u_pc_cls (
    .addr_i (pc_next_i),
    .cls_o  (pc_cls)
  );

  // Access decisions: the output location is tested first, stores only
  logic ld_bad, st_bad, pc_bad, emit, we;

  always_comb begin
    emit   = store_i & ea_cls.is_out;
    we     = store_i & ~ea_cls.is_out & cls_legal(ea_cls);
    st_bad = store_i & ~ea_cls.is_out & ~cls_legal(ea_cls);
    ld_bad = load_i & ~cls_legal(ea_cls);
    pc_bad = pc_upd_i & ~cls_legal(pc_cls) & ~pc_cls.is_halt;
  end

  lsu_guard_regs #(.CHAR_W(CHAR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ld_bad_i   (ld_bad),
    .st_bad_i   (st_bad),
    .pc_bad_i   (pc_bad),
    .emit_i     (emit),
    .char_i     (store_data_i[CHAR_W-1:0]),
    .ld_fault_o (ld_fault_o),
    .st_fault_o (st_fault_o),
    .pc_fault_o (pc_fault_o),
    .char_vld_o (char_vld_o),
    .char_o     (char_o)
  );

  assign ea_o     = ea;
  assign mem_we_o = we;

endmodule

// File: rtl/lsu_addr_guard_chk.sv
module lsu_addr_guard_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] MEM_LIMIT = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] OUT_ADDR  = 32'hFFFF_000C,
  parameter logic [ADDR_W-1:0] HALT_PC   = 32'hFEE1_DEAD
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              store_i,
  input logic [ADDR_W-1:0] store_data_i,
  input logic [ADDR_W-1:0] pc_next_i,
  input logic              pc_upd_i,
  input logic [ADDR_W-1:0] ea_o,
  input logic              mem_we_o,
  input logic              ld_fault_o,
  input logic              st_fault_o,
  input logic              pc_fault_o,
  input logic              char_vld_o,
  input logic [CHAR_W-1:0] char_o
);

  // R2
  we_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (store_i && ea_o[1:0] == 2'b00 && ea_o < MEM_LIMIT));

  // R3
  out_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && ea_o == OUT_ADDR) |-> !mem_we_o);

  // R3
  out_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && ea_o == OUT_ADDR) |=>
      (char_vld_o && char_o == $past(store_data_i[CHAR_W-1:0])));

  // R4
  strobe_only_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_i && ea_o == OUT_ADDR) |=> (!char_vld_o && $stable(char_o)));

  // R5
  ld_out_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && ea_o == OUT_ADDR) |=> ld_fault_o);

  // R5
  ld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault_o |=> ld_fault_o);

  // R6
  st_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_fault_o |=> st_fault_o);

  // R7
  halt_pc_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_upd_i && !pc_fault_o && pc_next_i == HALT_PC) |=> !pc_fault_o);

  // R7
  pc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_fault_o |=> pc_fault_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !store_i && !pc_upd_i && !ld_fault_o && !st_fault_o && !pc_fault_o)
      |=> (!ld_fault_o && !st_fault_o && !pc_fault_o && !char_vld_o));

endmodule

bind lsu_addr_guard lsu_addr_guard_chk #(
  .ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .MEM_LIMIT(MEM_LIMIT),
  .OUT_ADDR(OUT_ADDR), .HALT_PC(HALT_PC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .load_i       (load_i),
  .store_i      (store_i),
  .store_data_i (store_data_i),
  .pc_next_i    (pc_next_i),
  .pc_upd_i     (pc_upd_i),
  .ea_o         (ea_o),
  .mem_we_o     (mem_we_o),
  .ld_fault_o   (ld_fault_o),
  .st_fault_o   (st_fault_o),
  .pc_fault_o   (pc_fault_o),
  .char_vld_o   (char_vld_o),
  .char_o       (char_o)
);

// File: tb/lsu_addr_guard_tb.sv
`timescale 1ns/1ps
module lsu_addr_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic        load_i = 1'b0;
  logic        store_i = 1'b0;
  logic [31:0] store_data_i = '0;
  logic [31:0] pc_next_i = '0;
  logic        pc_upd_i = 1'b0;
  logic [31:0] ea_o;
  logic        mem_we_o, ld_fault_o, st_fault_o, pc_fault_o, char_vld_o;
  logic [7:0]  char_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lsu_addr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .base_i(base_i), .offset_i(offset_i),
    .load_i(load_i), .store_i(store_i), .store_data_i(store_data_i),
    .pc_next_i(pc_next_i), .pc_upd_i(pc_upd_i), .ea_o(ea_o),
    .mem_we_o(mem_we_o), .ld_fault_o(ld_fault_o), .st_fault_o(st_fault_o),
    .pc_fault_o(pc_fault_o), .char_vld_o(char_vld_o), .char_o(char_o)
  );

  // Small word memory model
  logic [31:0] mem [0:15];
  always @(posedge clk) if (mem_we_o) mem[ea_o[5:2]] <= store_data_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [31:0] a);
    return (a % 4 == 0) && (a < 32'h0100_0000);
  endfunction

  task automatic idle();
    load_i = 0; store_i = 0; pc_upd_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    #2;
    chk(!ld_fault_o && !st_fault_o && !pc_fault_o, "R8 flags", {29'd0, ld_fault_o, st_fault_o, pc_fault_o}, 0);
    chk(!char_vld_o && char_o == 8'h00, "R8 char", {23'd0, char_vld_o, char_o}, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // One access cycle: drive at negedge, return at next negedge
  task automatic access(input logic [31:0] b, input logic [15:0] o, input bit ld, input bit st,
                        input logic [31:0] d);
    base_i = b; offset_i = o; load_i = ld; store_i = st; store_data_i = d;
    #2;
    @(negedge clk);
    idle();
  endtask

  task automatic pc_try(input logic [31:0] p, input bit upd);
    pc_next_i = p; pc_upd_i = upd;
    @(negedge clk);
    idle();
  endtask

  logic [31:0] bases [0:9];
  logic [15:0] offs [0:11];

  initial begin
    bases = '{32'h0, 32'h4, 32'h00FF_FFFC, 32'h0100_0000, 32'hFFFF_0000,
              32'hFFFF_000C, 32'h7FFF_FFFE, 32'hFFFF_FFFC, 32'h2, 32'h1234_5678};
    offs  = '{16'h0, 16'h1, 16'h2, 16'h3, 16'h4, 16'hFFFC, 16'hFFFF,
              16'h7FFF, 16'h8000, 16'h000C, 16'h0010, 16'hFFF8};
    for (int i = 0; i < 16; i++) mem[i] = 32'hA5A5_0000 + i;

    repeat (3) @(posedge clk);
    do_reset();

    // R1, R2, R3: sweep of base and offset with a store strobe
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 12; j++) begin
        logic [31:0] exp_ea;
        bit exp_we;
        @(negedge clk);
        base_i = bases[i]; offset_i = offs[j]; store_i = 1; store_data_i = 32'h0;
        exp_ea = bases[i] + {{16{offs[j][15]}}, offs[j]};
        exp_we = legal(exp_ea) && exp_ea != 32'hFFFF_000C;
        #2;
        chk(ea_o == exp_ea, "R1 ea", ea_o, exp_ea);
        chk(mem_we_o == exp_we, "R2 we", {31'd0, mem_we_o}, {31'd0, exp_we});
        store_i = 0;
      end
    end
    // R1: no strobe still computes address, R9: no write
    @(negedge clk);
    base_i = 32'hFFFF_FFF0; offset_i = 16'h0014; #2;
    chk(ea_o == 32'h4, "R1 wrap", ea_o, 32'h4);
    chk(!mem_we_o, "R9 no store no we", {31'd0, mem_we_o}, 0);

    do_reset();
    // R9: idle with illegal addresses and PC, no strobes
    base_i = 32'h3; offset_i = 0; pc_next_i = 32'h1;
    repeat (2) @(negedge clk);
    chk(!ld_fault_o && !st_fault_o && !pc_fault_o && !char_vld_o, "R9 idle",
        {28'd0, ld_fault_o, st_fault_o, pc_fault_o, char_vld_o}, 0);

    // R3, R4: every character through the output location
    access(32'h20, 16'h0, 0, 1, 32'hCAFE_BE00);   // legal write to word 8
    for (int c = 0; c < 256; c++) begin
      logic [31:0] data;
      data = {24'h5A5A5A, 8'(c)};
      base_i = 32'hFFFF_0000; offset_i = 16'h000C; store_i = 1; store_data_i = data;
      #2;
      chk(!mem_we_o, "R3 no write", {31'd0, mem_we_o}, 0);
      @(negedge clk);
      idle();
      chk(char_vld_o && char_o == 8'(c), "R3 char", {23'd0, char_vld_o, char_o}, {23'd1, 8'(c)});
      @(negedge clk);
      chk(!char_vld_o && char_o == 8'(c), "R4 pulse", {23'd0, char_vld_o, char_o}, {23'd0, 8'(c)});
    end
    chk(mem[8] == 32'hCAFE_BE00, "R3 memory", mem[8], 32'hCAFE_BE00);
    chk(mem[3] == 32'hA5A5_0003, "R3 memory", mem[3], 32'hA5A5_0003);
    chk(!st_fault_o && !ld_fault_o, "R3 no fault", {30'd0, st_fault_o, ld_fault_o}, 0);

    // R5: legal load, then load from output location
    access(32'h0, 16'h0010, 1, 0, 0);
    chk(!ld_fault_o, "R5 legal load", {31'd0, ld_fault_o}, 0);
    access(32'hFFFF_0000, 16'h000C, 1, 0, 0);
    chk(ld_fault_o, "R5 load out", {31'd0, ld_fault_o}, 1);
    chk(!char_vld_o, "R5 no char", {31'd0, char_vld_o}, 0);
    repeat (3) @(negedge clk);
    chk(ld_fault_o, "R5 sticky", {31'd0, ld_fault_o}, 1);

    // R6: out of range store
    base_i = 32'h0100_0000; offset_i = 0; store_i = 1; store_data_i = 32'h1; #2;
    chk(!mem_we_o, "R6 no we", {31'd0, mem_we_o}, 0);
    @(negedge clk); idle();
    chk(st_fault_o, "R6 range", {31'd0, st_fault_o}, 1);
    repeat (2) @(negedge clk);
    chk(st_fault_o, "R6 sticky", {31'd0, st_fault_o}, 1);

    // R8: reset clears
    do_reset();
    chk(!ld_fault_o && !st_fault_o, "R8 cleared", {30'd0, ld_fault_o, st_fault_o}, 0);

    // R6: misaligned store
    access(32'h4, 16'h0002, 0, 1, 32'h1);
    chk(st_fault_o && !ld_fault_o, "R6 misaligned", {30'd0, st_fault_o, ld_fault_o}, 32'h2);

    do_reset();
    // R7: PC targets
    pc_try(32'hFEE1_DEAD, 1);
    chk(!pc_fault_o, "R7 halt", {31'd0, pc_fault_o}, 0);
    pc_try(32'h00FF_FFFC, 1);
    chk(!pc_fault_o, "R7 top word", {31'd0, pc_fault_o}, 0);
    pc_try(32'h0000_0006, 0);
    chk(!pc_fault_o, "R9 pc no upd", {31'd0, pc_fault_o}, 0);
    pc_try(32'hFEE1_DEAC, 1);
    chk(pc_fault_o, "R7 near halt", {31'd0, pc_fault_o}, 1);
    pc_try(32'h0, 1);
    chk(pc_fault_o, "R7 sticky", {31'd0, pc_fault_o}, 1);
    do_reset();
    pc_try(32'hFFFF_000C, 1);
    chk(pc_fault_o, "R7 out addr as pc", {31'd0, pc_fault_o}, 1);
    pc_try(32'h0100_0000, 1);
    chk(pc_fault_o && !ld_fault_o && !st_fault_o, "R7 limit",
        {29'd0, pc_fault_o, ld_fault_o, st_fault_o}, 32'h4);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule